// File: doc/BRIEF.md
# Floating-Point Sign Injection and Min/Max Unit

This unit takes two IEEE-754 binary floating-point operands, which are single precision by default, together with an operation group code and a subcode. It returns either a sign-injected copy of the first operand or the smaller or larger of the two operands, along with a five-bit exception flag vector. It serves as the sign-manipulation and selection lane of a scalar floating-point pipeline. A request is accepted on any cycle in which `in_valid` is high. Its result and flags appear together one clock later, qualified by `out_valid`.

Two states sequence the output. `ST_IDLE` means no result was captured on the previous edge. `ST_DONE` means a result was captured on the previous edge. There are four transitions:
- IDLE→DONE, taken on a strobe.
- DONE→DONE, taken on a back-to-back strobe.
- DONE→IDLE, taken when there is no strobe.
- IDLE→IDLE, taken when there is no strobe.

`out_valid` is high exactly in `ST_DONE`.

For min/max, NaN operands follow these rules:
- If either operand is NaN, the other operand is returned.
- If both operands are NaN, the canonical quiet NaN is returned.
- A signaling NaN on either side raises the invalid flag.

Signed zeros are ordered so that -0 is below +0.

Top module: `fpsm_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_result` and `out_flags` are all zero until the first strobe.
- R2: Group 0x10 with subcode 0 returns operand B's sign bit above operand A's lower 31 bits (exponent and fraction).
- R3: Group 0x10 with subcode 1 returns the inverted sign of operand B above operand A's lower 31 bits.
- R4: Group 0x10 with subcode 2 returns the XOR of both signs above operand A's lower 31 bits.
- R5: Sign-injection operations never raise any flag, and they pass a NaN payload in operand A through bit for bit.
- R6: Group 0x14 returns the minimum when the subcode is 0 and the maximum for any nonzero subcode. For non-NaN operands, ordering is by sign and magnitude, so among negatives the larger magnitude is the smaller value.
- R7: When +0 (0x00000000) is compared with -0 (0x80000000), maximum returns +0 and minimum returns -0, regardless of operand order.
- R8: If both min/max operands are NaN, the result is the canonical quiet NaN 0x7FC00000.
- R9: If exactly one min/max operand is NaN, the result is the other operand unchanged.
- R10: A signaling NaN has an all-ones exponent (0xFF), a nonzero fraction and fraction bit 22 clear. If either min/max operand is a signaling NaN, flag bit 4 (invalid, value 0x10) is set and all other flag bits are zero. Quiet NaNs, with fraction bit 22 set, raise no flag.
- R11: `out_valid` is high exactly one cycle after `in_valid`, and result and flags update together. On cycles with no strobe, `out_result` and `out_flags` keep their previous values.
- R12: Any other group code, and group 0x10 with subcode 3 to 7, yields result 0 and flags 0, with `out_valid` still asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | Operand A (EXP_W+MAN_W+1 bits) |
| op_b | input | 32 | Operand B |
| op_group | input | 7 | Operation group: 0x10 sign injection, 0x14 min/max |
| op_sub | input | 3 | Subcode within the group |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 32 | Registered result |
| out_flags | output | 5 | Exception flags: bit4 invalid, bit3 divide-by-zero, bit2 overflow, bit1 underflow, bit0 inexact |

## Verification
The bench builds the unit with its default parameters, EXP_W = 8 and MAN_W = 23. This makes the canonical NaN exactly 0x7FC00000 and places the quiet bit at fraction bit 22, so the exact values in the requirements can be compared directly. A random pool mixes signed zeros, infinities, quiet and signaling NaNs, and equal-magnitude pairs of opposite sign. This brings the NaN-selection, flag and signed-zero paths within reach alongside ordinary sign-magnitude ordering among negative operands.

// File: rtl/fpsm_pkg.sv
package fpsm_pkg;
    localparam logic [6:0] GRP_SGNJ   = 7'h10;
    localparam logic [6:0] GRP_MINMAX = 7'h14;
    localparam int         NFLAGS     = 5;
    localparam int         FLAG_NV    = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } fpsm_state_t;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } fp_class_t;
endpackage

// File: rtl/fpsm_classify.sv
module fpsm_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val,
    output fpsm_pkg::fp_class_t  cls
);
    localparam int W = EXP_W + MAN_W + 1;

    logic exp_ones;
    logic frac_nz;
    logic quiet_bit;

    always_comb begin
        exp_ones    = &val[W-2:MAN_W];
        frac_nz     = |val[MAN_W-1:0];
        quiet_bit   = val[MAN_W-1];
        cls.is_nan  = exp_ones & frac_nz;
        cls.is_snan = exp_ones & frac_nz & ~quiet_bit;
    end
endmodule

// File: rtl/fpsm_sgnj.sv
module fpsm_sgnj #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   sub,
    output logic [W-1:0] result,
    output logic         supported
);
    logic new_sign;

    always_comb begin
        new_sign  = 1'b0;
        supported = 1'b1;
        unique case (sub)
            3'd0:    new_sign = b[W-1];
            3'd1:    new_sign = ~b[W-1];
            3'd2:    new_sign = a[W-1] ^ b[W-1];
            default: supported = 1'b0;
        endcase
        result = supported ? {new_sign, a[W-2:0]} : '0;
    end
endmodule

// File: rtl/fpsm_minmax.sv
module fpsm_minmax #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    input  fpsm_pkg::fp_class_t  cls_a,
    input  fpsm_pkg::fp_class_t  cls_b,
    input  logic                 take_max,
    output logic [EXP_W+MAN_W:0] result,
    output logic                 invalid
);
    localparam int W = EXP_W + MAN_W + 1;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic         sa, sb;
    logic [W-2:0] ma, mb;
    logic         a_lt_b, b_lt_a, pick_b;

    always_comb begin
        sa = a[W-1];
        sb = b[W-1];
        ma = a[W-2:0];
        mb = b[W-2:0];
        // sign first; among negatives a larger magnitude is smaller
        if (sa != sb) begin
            a_lt_b = sa;
            b_lt_a = sb;
        end else if (sa) begin
            a_lt_b = ma > mb;
            b_lt_a = mb > ma;
        end else begin
            a_lt_b = ma < mb;
            b_lt_a = mb < ma;
        end
        pick_b  = take_max ? a_lt_b : b_lt_a;
        invalid = cls_a.is_snan | cls_b.is_snan;
        if (cls_a.is_nan && cls_b.is_nan) result = CANON_NAN;
        else if (cls_a.is_nan)            result = b;
        else if (cls_b.is_nan)            result = a;
        else                              result = pick_b ? b : a;
    end

    // R6: with no NaN present the output is always one of the inputs
    always_comb begin
        if (!cls_a.is_nan && !cls_b.is_nan)
            a_r6_pick_operand: assert (result == a || result == b);
    end
endmodule

// File: rtl/fpsm_unit.sv
module fpsm_unit #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  logic [6:0]           op_group,
    input  logic [2:0]           op_sub,
    output logic                 out_valid,
    output logic [EXP_W+MAN_W:0] out_result,
    output logic [4:0]           out_flags
);
    import fpsm_pkg::*;

    localparam int W = EXP_W + MAN_W + 1;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    fpsm_state_t state, state_nx;

    logic [W-1:0] ops [2];
    fp_class_t    cls [2];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpsm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val (ops[gi]),
            .cls (cls[gi])
        );
    end

    logic [W-1:0] sgnj_res, mm_res, sel_res;
    logic         sgnj_ok, mm_invalid;
    logic [NFLAGS-1:0] sel_flags;
    logic         is_sgnj, is_mm;

    fpsm_sgnj #(.W(W)) u_sgnj (
        .a         (op_a),
        .b         (op_b),
        .sub       (op_sub),
        .result    (sgnj_res),
        .supported (sgnj_ok)
    );

    fpsm_minmax #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_minmax (
        .a        (op_a),
        .b        (op_b),
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .take_max (|op_sub),
        .result   (mm_res),
        .invalid  (mm_invalid)
    );

    always_comb begin
        is_sgnj   = (op_group == GRP_SGNJ);
        is_mm     = (op_group == GRP_MINMAX);
        sel_res   = '0;
        sel_flags = '0;
        if (is_sgnj && sgnj_ok) begin
            sel_res = sgnj_res;
        end else if (is_mm) begin
            sel_res            = mm_res;
            sel_flags[FLAG_NV] = mm_invalid;
        end
    end

    // next-state logic
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_nx = in_valid ? ST_DONE : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
            out_flags  <= '0;
        end else if (in_valid) begin
            out_result <= sel_res;
            out_flags  <= sel_flags;
        end
    end

    assign out_valid = (state == ST_DONE);

    // R11: valid tracks the strobe one cycle later
    a_r11_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_flags)));
    // R5: sign injection is flag-free
    a_r5_sgnj_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_sgnj) |=> (out_flags == '0));
    // R2: low bits come from operand A on supported sign-injection subcodes
    a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_sgnj && op_sub < 3'd3) |=> (out_result[W-2:0] == $past(op_a[W-2:0])));
    // R10: signaling NaN in min/max raises invalid
    a_r10_snan_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_mm && (cls[0].is_snan || cls[1].is_snan)) |=> out_flags[FLAG_NV]);
    // R8: two NaNs collapse to the canonical NaN
    a_r8_canon: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_mm && cls[0].is_nan && cls[1].is_nan) |=> (out_result == CANON_NAN));
    // R12: unsupported groups produce zero
    a_r12_unsup: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_sgnj && !is_mm) |=> (out_result == '0 && out_flags == '0));
endmodule

// File: tb/fpsm_unit_bench.sv
module fpsm_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [6:0]  op_group = '0;
    logic [2:0]  op_sub = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  out_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpsm_unit u_fpsm_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_a       (op_a),
        .op_b       (op_b),
        .op_group   (op_group),
        .op_sub     (op_sub),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_flags  (out_flags)
    );

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic bit is_snan(input logic [31:0] x);
        return is_nan(x) && !x[22];
    endfunction

    // total-order key for non-NaN values: -0 sits just below +0
    function automatic logic [31:0] okey(input logic [31:0] x);
        return x[31] ? ~x : (x | 32'h8000_0000);
    endfunction

    function automatic logic [31:0] ref_result(input logic [31:0] a, input logic [31:0] b,
                                               input logic [6:0] g, input logic [2:0] s);
        if (g == 7'h10) begin
            case (s)
                3'd0: return {b[31], a[30:0]};
                3'd1: return {~b[31], a[30:0]};
                3'd2: return {a[31] ^ b[31], a[30:0]};
                default: return 32'h0;
            endcase
        end else if (g == 7'h14) begin
            if (is_nan(a) && is_nan(b)) return 32'h7FC0_0000;
            if (is_nan(a)) return b;
            if (is_nan(b)) return a;
            if (s != 0) return (okey(b) > okey(a)) ? b : a;
            return (okey(b) < okey(a)) ? b : a;
        end
        return 32'h0;
    endfunction

    function automatic logic [4:0] ref_flags(input logic [31:0] a, input logic [31:0] b,
                                             input logic [6:0] g);
        if (g == 7'h14 && (is_snan(a) || is_snan(b))) return 5'h10;
        return 5'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // apply one request, then sample one cycle later away from the edge
    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [6:0] g, input logic [2:0] s);
        @(negedge clk);
        op_a = a; op_b = b; op_group = g; op_sub = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'b0, out_valid}, 32'd1);
        check({req, " result"}, out_result, ref_result(a, b, g, s));
        check({req, " flags"}, {27'b0, out_flags}, {27'b0, ref_flags(a, b, g)});
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom_range(0, 9))
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7F80_0000;
            3: return 32'hFF80_0000;
            4: return 32'h7FC0_0000 | ($urandom & 32'h803F_FFFF);
            5: return 32'h7F80_0001 | ($urandom & 32'h801F_FFFF);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20211010));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {31'b0, out_valid}, 32'd0);
        check("R1 result", out_result, 32'd0);
        check("R1 flags", {27'b0, out_flags}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {31'b0, out_valid}, 32'd0);

        run_op("R2 copy sign", 32'h3F80_0000, 32'hC000_0000, 7'h10, 3'd0);
        run_op("R3 inverted sign", 32'hBF80_0000, 32'hC000_0000, 7'h10, 3'd1);
        run_op("R4 xor sign", 32'hBF80_0000, 32'hC000_0000, 7'h10, 3'd2);
        run_op("R5 snan payload", 32'h7F80_1234, 32'h8000_0000, 7'h10, 3'd0);
        run_op("R6 min positives", 32'h4000_0000, 32'h3F80_0000, 7'h14, 3'd0);
        run_op("R6 max negatives", 32'hC000_0000, 32'hBF80_0000, 7'h14, 3'd1);
        run_op("R6 min mixed sign", 32'h3F80_0000, 32'hBF80_0000, 7'h14, 3'd0);
        run_op("R7 max +0 -0", 32'h8000_0000, 32'h0000_0000, 7'h14, 3'd5);
        run_op("R7 min +0 -0", 32'h0000_0000, 32'h8000_0000, 7'h14, 3'd0);
        run_op("R8 both qnan", 32'h7FC0_0001, 32'hFFC0_0000, 7'h14, 3'd0);
        run_op("R8 both snan", 32'h7F80_0001, 32'h7F80_0002, 7'h14, 3'd1);
        run_op("R9 a qnan", 32'h7FC0_0000, 32'hC120_0000, 7'h14, 3'd1);
        run_op("R9 b snan", 32'h4120_0000, 32'hFF80_0005, 7'h14, 3'd0);
        run_op("R10 qnan no flag", 32'h7FE0_0000, 32'h0000_0001, 7'h14, 3'd0);
        run_op("R12 bad group", 32'h3F80_0000, 32'h4000_0000, 7'h2C, 3'd0);
        run_op("R12 bad subcode", 32'h3F80_0000, 32'h4000_0000, 7'h10, 3'd6);

        // R11: no strobe keeps outputs and drops valid
        @(negedge clk);
        op_a = 32'h1234_5678; op_group = 7'h10; op_sub = 3'd0;
        @(negedge clk);
        check("R11 idle valid", {31'b0, out_valid}, 32'd0);
        check("R11 hold result", out_result, 32'd0);

        // R11: back-to-back strobes
        @(negedge clk);
        op_a = 32'h4040_0000; op_b = 32'hC040_0000; op_group = 7'h14; op_sub = 3'd1;
        in_valid = 1'b1;
        @(negedge clk);
        check("R11 b2b first", out_result, 32'h4040_0000);
        op_sub = 3'd0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 b2b second", out_result, 32'hC040_0000);
        check("R11 b2b valid", {31'b0, out_valid}, 32'd1);

        // random mix covering R2..R10 and R12
        for (int i = 0; i < 400; i++) begin
            logic [6:0] g;
            case ($urandom_range(0, 4))
                0, 1: g = 7'h10;
                2, 3: g = 7'h14;
                default: g = 7'($urandom);
            endcase
            run_op("R6 R9 R10 random", pick_operand(), pick_operand(), g,
                   3'($urandom_range(0, 7)));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule